// File: doc/BRIEF.md
# Page-Mode Burst Read Sequencer

This block turns a stream of byte-addressed read requests into read cycles on an external asynchronous memory that supports page mode. A memory page is a naturally aligned group of 4, 8, 16 or 32 bytes. The first read into a page takes the memory longer than later reads that stay inside the same page. The sequencer tracks which page is open. It charges each access either a long first-access count or a short in-page count of clock cycles. Chip select and read strobe stay asserted across a run of back-to-back requests.

When page mode is switched off, every request gets a plain single read. That read has a setup phase with the strobes inactive, an active pulse phase, and a hold phase. The memory data width is configurable. For 16-bit and 32-bit memories, the byte-lane address bits the memory ignores are driven as zero. Read data goes back as a one-cycle valid pulse with the sampled data word. All configuration inputs are assumed static while the block is busy.

Top module: `pgrd_seq`

## Requirements
- R1: While reset is asserted and just after it, `mem_cs_n` and `mem_rd_n` are high, `rd_valid` is low and `req_ready` is high.
- R2: With `cfg_page_en` set, a request accepted while the block is idle gets an access of `cfg_first_cyc` cycles. `rd_valid` rises exactly that many clock edges after the accepting edge.
- R3: In page mode, a request presented during an access is accepted on that access's last cycle, with no dead cycle. If its page-address bits match the open page, its access lasts `cfg_next_cyc` cycles.
- R4: `cfg_page_sz` encodes the page size: 0 gives 4 bytes, 1 gives 8 bytes, 2 gives 16 bytes, 3 gives 32 bytes. The page address is the request address with the low 2, 3, 4 or 5 bits dropped. A back-to-back request whose page address differs pays `cfg_first_cyc` again.
- R5: `mem_cs_n` and `mem_rd_n` always have equal values. In page mode they stay low through every cycle of a back-to-back burst, whatever `cfg_setup_cyc` and `cfg_hold_cyc` hold.
- R6: When an access ends with no request presented, the strobes go high on the next cycle and the open page is forgotten. The next request pays `cfg_first_cyc` even if it is in the same page.
- R7: With `cfg_page_en` clear, an access runs `cfg_setup_cyc` cycles with the strobes high, then the pulse count with the strobes low, then `cfg_hold_cyc` cycles high. The next request is accepted one cycle after the hold ends.
- R8: `cfg_bus_w` encodes the memory width: 0 is 8-bit, 1 is 16-bit, 2 or 3 is 32-bit. `mem_addr` bit 0 is zero for 16-bit memories, and bits [1:0] are zero for 32-bit memories. All other bits follow the request address.
- R9: `rd_data` carries `mem_data` as sampled on the last cycle of the strobe-low part of the access. It is presented with `rd_valid` high for one cycle per request, in request order. `mem_addr` changes only when a request is accepted.
- R10: A value of zero in `cfg_first_cyc`, `cfg_next_cyc` or `cfg_pulse_cyc` behaves as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_en | input | 1 | Enables page-mode bursts |
| cfg_page_sz | input | 2 | Page size code (4/8/16/32 bytes) |
| cfg_bus_w | input | 2 | Memory data width code |
| cfg_first_cyc | input | CNT_W | Cycles of a first access into a page |
| cfg_next_cyc | input | CNT_W | Cycles of an in-page access |
| cfg_setup_cyc | input | CNT_W | Single-read setup cycles |
| cfg_pulse_cyc | input | CNT_W | Single-read strobe-low cycles |
| cfg_hold_cyc | input | CNT_W | Single-read hold cycles |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Request byte address |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_data | input | DATA_W | Memory data bus |

## Verification
The bench targets the page-boundary decision at every page size. If the boundary mask were off by one bit, either a miss would be served with the short count and the bench would see `rd_valid` early, or a true hit would be slowed down. Gaps placed between same-page requests check that an idle cycle forgets the page; a design that kept the page would return data too early after the gap. Back-to-back requests expose any design that inserts an idle cycle between accesses, or that drops the strobes between accesses, through the accept timing and the strobe-low cycle total. Zero counts and 16/32-bit addresses check the one-cycle floor and the lane masking, which show up as hangs, wrong latency or wrong returned data.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

  // Widest in-page offset (32-byte page) in address bits.
  localparam int unsigned OFS_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_PAGE  = 3'd4
  } seq_state_t;

  // Low-address bits that select data inside a page, per size code.
  function automatic logic [OFS_W-1:0] page_low_mask(input logic [1:0] sz);
    logic [OFS_W-1:0] m;
    unique case (sz)
      2'd0:    m = 5'b00011;
      2'd1:    m = 5'b00111;
      2'd2:    m = 5'b01111;
      default: m = 5'b11111;
    endcase
    return m;
  endfunction

  // Byte-lane address bits the memory ignores, per width code.
  function automatic logic [1:0] lane_drop_mask(input logic [1:0] bw);
    logic [1:0] m;
    unique case (bw)
      2'd0:    m = 2'b00;
      2'd1:    m = 2'b01;
      default: m = 2'b11;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pgrd_addr_map.sv
module pgrd_addr_map #(
  parameter int unsigned ADDR_W = 26
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        page_sz_i,
  input  logic [1:0]        bus_w_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] tag_o
);
  import pgrd_pkg::*;

  localparam int unsigned LANE_W = 2;

  logic [OFS_W-1:0]  pmask;
  logic [LANE_W-1:0] dmask;

  assign pmask = page_low_mask(page_sz_i);
  assign dmask = lane_drop_mask(bus_w_i);

  // Per-bit selection: lane bits may be dropped, offset bits are removed
  // from the tag, upper bits pass through to both.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b < LANE_W) begin : g_lane
      assign mem_addr_o[b] = addr_i[b] & ~dmask[b];
      assign tag_o[b]      = 1'b0;
    end else if (b < OFS_W) begin : g_ofs
      assign mem_addr_o[b] = addr_i[b];
      assign tag_o[b]      = addr_i[b] & ~pmask[b];
    end else begin : g_up
      assign mem_addr_o[b] = addr_i[b];
      assign tag_o[b]      = addr_i[b];
    end
  end

endmodule

// File: rtl/pgrd_page_tag.sv
module pgrd_page_tag #(
  parameter int unsigned ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] tag_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] tag_q;
  logic              vld_q;
  logic              vld_d;
  logic              vld_en;

  assign vld_en = load_i | clear_i;
  assign vld_d  = load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (load_i) begin
      tag_q <= tag_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (vld_en) begin
      vld_q <= vld_d;
    end
  end

  assign hit_o = vld_q && (tag_q == tag_i);

endmodule

// File: rtl/pgrd_timer.sv
module pgrd_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = (len_i == '0) ? ONE : len_i;
    end else if (cnt_q > ONE) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ONE;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q <= ONE);

endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_page_en,
  input  logic [CNT_W-1:0] cfg_first_cyc,
  input  logic [CNT_W-1:0] cfg_next_cyc,
  input  logic [CNT_W-1:0] cfg_setup_cyc,
  input  logic [CNT_W-1:0] cfg_pulse_cyc,
  input  logic [CNT_W-1:0] cfg_hold_cyc,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             page_hit_i,
  input  logic             tmr_last_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_len_o,
  output logic             tag_load_o,
  output logic             tag_clear_o,
  output logic             capture_o,
  output logic             strobe_o
);
  import pgrd_pkg::*;

  seq_state_t state_q;
  seq_state_t state_d;

  always_comb begin
    state_d     = state_q;
    req_ready_o = 1'b0;
    tmr_load_o  = 1'b0;
    tmr_len_o   = cfg_first_cyc;
    tag_load_o  = 1'b0;
    tag_clear_o = 1'b0;
    capture_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready_o = 1'b1;
        if (req_valid_i) begin
          tmr_load_o = 1'b1;
          if (cfg_page_en) begin
            state_d    = ST_PAGE;
            tmr_len_o  = cfg_first_cyc;
            tag_load_o = 1'b1;
          end else if (cfg_setup_cyc != '0) begin
            state_d   = ST_SETUP;
            tmr_len_o = cfg_setup_cyc;
          end else begin
            state_d   = ST_PULSE;
            tmr_len_o = cfg_pulse_cyc;
          end
        end
      end
      ST_SETUP: begin
        if (tmr_last_i) begin
          state_d    = ST_PULSE;
          tmr_load_o = 1'b1;
          tmr_len_o  = cfg_pulse_cyc;
        end
      end
      ST_PULSE: begin
        if (tmr_last_i) begin
          capture_o = 1'b1;
          if (cfg_hold_cyc != '0) begin
            state_d    = ST_HOLD;
            tmr_load_o = 1'b1;
            tmr_len_o  = cfg_hold_cyc;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_last_i) begin
          state_d = ST_IDLE;
        end
      end
      ST_PAGE: begin
        if (tmr_last_i) begin
          capture_o   = 1'b1;
          req_ready_o = cfg_page_en;
          if (req_valid_i && cfg_page_en) begin
            tmr_load_o = 1'b1;
            tmr_len_o  = page_hit_i ? cfg_next_cyc : cfg_first_cyc;
            tag_load_o = 1'b1;
          end else begin
            state_d     = ST_IDLE;
            tag_clear_o = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign strobe_o = (state_q == ST_PULSE) || (state_q == ST_PAGE);

endmodule

// File: rtl/pgrd_seq.sv
module pgrd_seq #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_page_en,
  input  logic [1:0]        cfg_page_sz,
  input  logic [1:0]        cfg_bus_w,
  input  logic [CNT_W-1:0]  cfg_first_cyc,
  input  logic [CNT_W-1:0]  cfg_next_cyc,
  input  logic [CNT_W-1:0]  cfg_setup_cyc,
  input  logic [CNT_W-1:0]  cfg_pulse_cyc,
  input  logic [CNT_W-1:0]  cfg_hold_cyc,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  input  logic [DATA_W-1:0] mem_data
);
  logic [ADDR_W-1:0] map_addr;
  logic [ADDR_W-1:0] map_tag;
  logic              page_hit;
  logic              tmr_last;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_len;
  logic              tag_load;
  logic              tag_clear;
  logic              capture;
  logic              strobe;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              vld_q;

  pgrd_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .addr_i     (req_addr),
    .page_sz_i  (cfg_page_sz),
    .bus_w_i    (cfg_bus_w),
    .mem_addr_o (map_addr),
    .tag_o      (map_tag)
  );

  pgrd_page_tag #(.ADDR_W(ADDR_W)) u_tag (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (tag_load),
    .clear_i (tag_clear),
    .tag_i   (map_tag),
    .hit_o   (page_hit)
  );

  pgrd_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .last_o (tmr_last)
  );

  pgrd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_page_en   (cfg_page_en),
    .cfg_first_cyc (cfg_first_cyc),
    .cfg_next_cyc  (cfg_next_cyc),
    .cfg_setup_cyc (cfg_setup_cyc),
    .cfg_pulse_cyc (cfg_pulse_cyc),
    .cfg_hold_cyc  (cfg_hold_cyc),
    .req_valid_i   (req_valid),
    .req_ready_o   (req_ready),
    .page_hit_i    (page_hit),
    .tmr_last_i    (tmr_last),
    .tmr_load_o    (tmr_load),
    .tmr_len_o     (tmr_len),
    .tag_load_o    (tag_load),
    .tag_clear_o   (tag_clear),
    .capture_o     (capture),
    .strobe_o      (strobe)
  );

  assign accept = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= map_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (capture) begin
      data_q <= mem_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= capture;
    end
  end

  assign mem_addr = addr_q;
  assign mem_cs_n = ~strobe;
  assign mem_rd_n = ~strobe;
  assign rd_data  = data_q;
  assign rd_valid = vld_q;

endmodule

// File: rtl/pgrd_seq_chk.sv
module pgrd_seq_chk #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_page_en,
  input logic [1:0]        cfg_bus_w,
  input logic [CNT_W-1:0]  cfg_setup_cyc,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_rd_n,
  input logic              rd_valid
);

  p_burst_stays_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_page_en && !mem_cs_n && req_valid && req_ready) |=> (!mem_cs_n && !mem_rd_n));

  p_setup_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_page_en && cfg_setup_cyc != '0 && req_valid && req_ready) |=> (mem_cs_n && mem_rd_n));

  p_sample_in_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_rd_n));

  p_addr_only_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(mem_addr));

  p_lane16_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bus_w == 2'd1 && !mem_cs_n) |-> !mem_addr[0]);

  p_lane32_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bus_w[1] && !mem_cs_n) |-> (mem_addr[1:0] == 2'b00));

endmodule

bind pgrd_seq pgrd_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_page_en   (cfg_page_en),
  .cfg_bus_w     (cfg_bus_w),
  .cfg_setup_cyc (cfg_setup_cyc),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_addr      (mem_addr),
  .mem_cs_n      (mem_cs_n),
  .mem_rd_n      (mem_rd_n),
  .rd_valid      (rd_valid)
);

// File: tb/pgrd_seq_tb_top.sv
module pgrd_seq_tb_top;
  localparam int AW = 26;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam int QD = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_page_en = 1'b0;
  logic [1:0]    cfg_page_sz = 2'd0;
  logic [1:0]    cfg_bus_w = 2'd0;
  logic [CW-1:0] cfg_first_cyc = '0;
  logic [CW-1:0] cfg_next_cyc = '0;
  logic [CW-1:0] cfg_setup_cyc = '0;
  logic [CW-1:0] cfg_pulse_cyc = '0;
  logic [CW-1:0] cfg_hold_cyc = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n;
  logic          mem_rd_n;
  logic [DW-1:0] mem_data;

  assign mem_data = {6'h15, mem_addr};

  pgrd_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_page_en(cfg_page_en), .cfg_page_sz(cfg_page_sz),
    .cfg_bus_w(cfg_bus_w), .cfg_first_cyc(cfg_first_cyc), .cfg_next_cyc(cfg_next_cyc),
    .cfg_setup_cyc(cfg_setup_cyc), .cfg_pulse_cyc(cfg_pulse_cyc), .cfg_hold_cyc(cfg_hold_cyc),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_data(mem_data)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench-side counters (driver) and monitor-side counters.
  int checks = 0, errors = 0;
  int m_checks = 0, m_errors = 0;
  int cs_low = 0;

  // Expected-response queue.
  int            q_cyc [QD];
  logic [DW-1:0] q_dat [QD];
  string         q_lbl [QD];
  int            q_head = 0, q_tail = 0;

  // Current configuration as seen by the model.
  int pg, psz, bw, first, nxt, setup, pulse, hold;
  bit seg_first;
  int prev_end;
  logic [AW-1:0] prev_tag;
  int exp_low, low_base;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [AW-1:0] lane_mask(input logic [AW-1:0] a, input int w);
    logic [AW-1:0] r;
    r = a;
    if (w == 1) r[0] = 1'b0;
    else if (w >= 2) r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic logic [AW-1:0] ofs_mask(input int s);
    return AW'((1 << (s + 2)) - 1);
  endfunction

  function automatic logic [AW-1:0] tag_of(input logic [AW-1:0] a);
    return lane_mask(a, bw) & ~ofs_mask(psz);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cyc);
    end
  endtask

  // Monitor: strobe pairing, strobe-low cycle count, response order/timing/data.
  always @(negedge clk) begin
    if (rst_n) begin
      m_checks++;
      if (mem_cs_n !== mem_rd_n) begin
        m_errors++;
        $display("FAIL R5 actual=%0b expected=%0b (rd_n vs cs_n)", mem_rd_n, mem_cs_n);
      end
      if (!mem_cs_n) cs_low++;
      if (rd_valid) begin
        m_checks++;
        if (q_head == q_tail) begin
          m_errors++;
          $display("FAIL R9 actual=1 expected=0 (unexpected rd_valid at cycle %0d)", cyc);
        end else begin
          if (cyc != q_cyc[q_head % QD]) begin
            m_errors++;
            $display("FAIL %s actual=%0d expected=%0d (rd_valid cycle)",
                     q_lbl[q_head % QD], cyc, q_cyc[q_head % QD]);
          end
          m_checks++;
          if (rd_data !== q_dat[q_head % QD]) begin
            m_errors++;
            $display("FAIL %s actual=%0h expected=%0h (rd_data)",
                     (bw != 0) ? "R8" : "R9", rd_data, q_dat[q_head % QD]);
          end
          q_head++;
        end
      end
    end
  end

  task automatic set_cfg(input int p, input int s, input int w, input int f, input int n,
                         input int su, input int pu, input int ho);
    @(posedge clk); #2;
    pg = p; psz = s; bw = w; first = f; nxt = n; setup = su; pulse = pu; hold = ho;
    cfg_page_en = p[0]; cfg_page_sz = 2'(s); cfg_bus_w = 2'(w);
    cfg_first_cyc = CW'(f); cfg_next_cyc = CW'(n);
    cfg_setup_cyc = CW'(su); cfg_pulse_cyc = CW'(pu); cfg_hold_cyc = CW'(ho);
    seg_first = 1'b1; exp_low = 0; low_base = cs_low;
  endtask

  task automatic send(input logic [AW-1:0] a, input int gap);
    int p, c, to, rdy, lat;
    bit hit;
    string lb;
    logic [AW-1:0] tg;
    repeat (gap) begin @(posedge clk); #2; end
    req_addr = a; req_valid = 1'b1; p = cyc + 1; to = 0;
    @(negedge clk);
    while (!req_ready && to < 400) begin to++; @(negedge clk); end
    if (!req_ready) begin
      check(1'b0, "R7", 0, 1);
      req_valid = 1'b0;
      return;
    end
    c = cyc + 1;
    tg = tag_of(a);
    if (seg_first) rdy = p;
    else rdy = (pg != 0) ? prev_end : prev_end + hold + 1;
    if (rdy < p) rdy = p;
    hit = (pg != 0) && !seg_first && (c == prev_end) && (tg == prev_tag);
    if (pg == 0) lb = "R7";
    else if (hit) lb = "R3";
    else if (seg_first) lb = "R2";
    else if (c != prev_end) lb = "R6";
    else lb = "R4";
    check(c == rdy, (pg != 0) ? "R3" : "R7", c, rdy);
    if (pg != 0) lat = hit ? eff(nxt) : eff(first);
    else lat = setup + eff(pulse);
    if ((pg != 0 && ((hit && nxt == 0) || (!hit && first == 0))) || (pg == 0 && pulse == 0))
      lb = "R10";
    exp_low += (pg != 0) ? lat : eff(pulse);
    q_cyc[q_tail % QD] = c + lat;
    q_dat[q_tail % QD] = {6'h15, lane_mask(a, bw)};
    q_lbl[q_tail % QD] = lb;
    q_tail++;
    prev_end = c + lat; prev_tag = tg; seg_first = 1'b0;
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic end_seg();
    int to;
    to = 0;
    while (q_head != q_tail && to < 500) begin @(posedge clk); to++; end
    check(q_head == q_tail, "R9", q_tail - q_head, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check((cs_low - low_base) == exp_low, "R5", cs_low - low_base, exp_low);
    check(mem_cs_n == 1'b1, "R6", mem_cs_n, 1);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks + m_checks, errors + m_errors);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] a;
    int f, n, len;
    void'($urandom(32'd4242));
    pg = 0; psz = 0; bw = 0; first = 1; nxt = 1; setup = 0; pulse = 1; hold = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(mem_cs_n == 1'b1, "R1", mem_cs_n, 1);
    check(mem_rd_n == 1'b1, "R1", mem_rd_n, 1);
    check(rd_valid == 1'b0, "R1", rd_valid, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", req_ready, 1);
    check(mem_cs_n == 1'b1, "R1", mem_cs_n, 1);

    // R2/R3/R4/R5: 8-byte pages, 32-bit bus, setup/hold ignored
    set_cfg(1, 1, 2, 5, 2, 3, 1, 2);
    send(26'h100, 0); send(26'h104, 0); send(26'h108, 0); send(26'h10F, 0);
    end_seg();
    // R6: gap forgets the open page
    set_cfg(1, 1, 2, 5, 2, 3, 1, 2);
    send(26'h200, 0); send(26'h201, 3); send(26'h202, 0);
    end_seg();
    // R4: 32-byte pages, 8-bit bus
    set_cfg(1, 3, 0, 4, 1, 0, 1, 0);
    send(26'h400, 0); send(26'h41F, 0); send(26'h420, 0); send(26'h43E, 0);
    end_seg();
    // R4/R8: 4-byte pages, 16-bit bus
    set_cfg(1, 0, 1, 3, 1, 0, 1, 0);
    send(26'h501, 0); send(26'h503, 0); send(26'h505, 0);
    end_seg();
    // R10: zero counts in page mode
    set_cfg(1, 2, 2, 0, 0, 0, 0, 0);
    send(26'h3F0, 0); send(26'h3F4, 0); send(26'h3FC, 0); send(26'h400, 0);
    end_seg();
    // R7/R8: single reads with setup, pulse and hold
    set_cfg(0, 1, 1, 6, 2, 2, 3, 1);
    send(26'h601, 0); send(26'h603, 0); send(26'h7FF, 0);
    end_seg();
    // R7/R10: single reads with all-zero timing
    set_cfg(0, 0, 2, 1, 1, 0, 0, 0);
    send(26'h013, 0); send(26'h017, 0);
    end_seg();

    // Constrained random segments
    for (int s = 0; s < 40; s++) begin
      f = int'($urandom % 7);
      n = int'($urandom % (eff(f) + 1));
      set_cfg(int'($urandom % 2), int'($urandom % 4), int'($urandom % 4), f, n,
              int'($urandom % 4), int'($urandom % 5), int'($urandom % 4));
      a = AW'($urandom);
      len = 1 + int'($urandom % 6);
      for (int k = 0; k < len; k++) begin
        if (k != 0) begin
          if ($urandom % 3 != 0) a = (a & ~ofs_mask(psz)) | (AW'($urandom) & ofs_mask(psz));
          else a = AW'($urandom);
        end
        send(a, ($urandom % 4 == 0) ? 1 + int'($urandom % 3) : 0);
      end
      end_seg();
    end

    $display("CHECKS %0d ERRORS %0d", checks + m_checks, errors + m_errors);
    $finish;
  end

endmodule